// File: doc/BRIEF.md
# Four-Word AHB-Lite Output Register Slave

This block is a bus slave for an AHB-Lite interconnect. It holds four 32-bit read/write words, and each word drives its own external 32-bit output bus continuously. The processor reaches the four words at consecutive word offsets 0 through 3 from the slave's base address, 0x6000_0000. The system decoder looks only at address bits [31:28], so the same four words also appear, repeated, across the whole 256 MB window whose top nibble is 6.

In the address phase of a transfer, the slave registers a 2-bit word index taken from HADDR[3:2] and a write flag. In the following data phase it either stores HWDATA into the indexed word or returns that word on HRDATA. The slave never inserts wait states and never signals an error. The result behaves like a single-word output port that has been widened from one address to four.

Top module: `ahb_quad_out`

## Requirements
- R1: While HRESETn is low, all four words clear to zero, so every `drive_*` bus and HRDATA read zero. A write whose address phase was accepted before the reset is dropped.
- R2: HREADYOUT is always 1 and HRESP is always 0 (OKAY), in reset and in operation.
- R3: A transfer is accepted when HSEL=1, HREADY=1 and HTRANS is NONSEQ (2'b10) or SEQ (2'b11). An accepted write with HSIZE=3'b010 updates the word numbered HADDR[3:2] with HWDATA at the clock edge that ends its data phase. The other three words keep their values.
- R4: In the data phase of an accepted read, HRDATA equals the word numbered by the HADDR[3:2] captured in that read's address phase.
- R5: Address bits other than HADDR[3:2] have no effect. Offsets such as 0x6ABC_0004 and 0x6FFF_FFF4 reach the same word as 0x6000_0004.
- R6: Transfers with HTRANS IDLE (2'b00) or BUSY (2'b01), transfers with HSEL=0, and address phases with HREADY=0 change no word.
- R7: A write whose HSIZE is not 3'b010 (byte 3'b000, halfword 3'b001, doubleword 3'b011) changes no word.
- R8: A read whose address phase overlaps the data phase of a write to the same word returns the newly written value.
- R9: `drive_0` to `drive_3` always equal words 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| HCLK | input | 1 | Bus clock |
| HRESETn | input | 1 | Asynchronous active-low reset |
| HSEL | input | 1 | Slave select from the decoder |
| HADDR | input | 32 | Transfer address |
| HTRANS | input | 2 | Transfer type |
| HWRITE | input | 1 | 1 = write, 0 = read |
| HSIZE | input | 3 | Transfer size; 3'b010 = 32-bit word |
| HREADY | input | 1 | Bus-wide ready; previous transfer completes |
| HWDATA | input | 32 | Write data (data phase) |
| HRDATA | output | 32 | Read data (data phase) |
| HREADYOUT | output | 1 | Slave ready, tied high |
| HRESP | output | 1 | Slave response, tied OKAY |
| drive_0 | output | 32 | Word 0 output bus |
| drive_1 | output | 32 | Word 1 output bus |
| drive_2 | output | 32 | Word 2 output bus |
| drive_3 | output | 32 | Word 3 output bus |

## Verification
The assertions assume a well-formed AHB-Lite master. HREADY stays high whenever this slave owns the data phase, because the slave never stalls, and HWDATA is valid in the cycle that follows an accepted write address phase. The stimulus always drives address and data on the falling clock edge, with one phase per cycle. It keeps HREADY high except in one deliberate address phase with HREADY low, and it inserts an IDLE cycle after each transfer, apart from one overlapped write-then-read pair. The sweep writes each word through three aliased base addresses, reads every word back, and checks all four output buses after each write.

// File: rtl/quadout_pkg.sv
package quadout_pkg;
   localparam int unsigned NUM_WORDS = 4;
   localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   localparam logic [2:0] SIZE_WORD = 3'b010;
endpackage

// File: rtl/qo_addr_capture.sv
module qo_addr_capture
   import quadout_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsel,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic              hready,
   output logic              wr_pend,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned IDX_LSB = 2;
   localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

   if (ADDR_W <= IDX_MSB + 1) begin : g_bad_addr
      $error("ADDR_W too small for word index");
   end

   logic xfer;
   assign xfer = hsel & hready & htrans[1];

   logic unused_addr;
   assign unused_addr = ^{haddr[ADDR_W-1:IDX_MSB+1], haddr[IDX_LSB-1:0], htrans[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend <= 1'b0;
         idx     <= '0;
      end else if (hready) begin
         wr_pend <= xfer & hwrite & (hsize == SIZE_WORD);
         if (xfer) idx <= haddr[IDX_MSB:IDX_LSB];
      end
   end

   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel && hready && htrans[1] && hwrite && hsize == SIZE_WORD)
      |=> (wr_pend && idx == $past(haddr[IDX_MSB:IDX_LSB])));

   p_no_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && !(hsel && htrans[1])) |=> !wr_pend);

   p_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hready && hsize != SIZE_WORD) |=> !wr_pend);
endmodule

// File: rtl/qo_reg_bank.sv
module qo_reg_bank
   import quadout_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_pend,
   input  logic                              hready,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [NUM_WORDS-1:0][DATA_W-1:0]  q
);
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end

   logic [NUM_WORDS-1:0] wr_sel;

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      assign wr_sel[g] = wr_pend & hready & (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q[g] <= '0;
         else if (wr_sel[g]) q[g] <= wdata;
      end

      p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
         wr_sel[g] |=> q[g] == $past(wdata));
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_pend && hready) |=> $stable(q));
endmodule

// File: rtl/qo_read_mux.sv
module qo_read_mux
   import quadout_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter bit          AND_OR = 1'b1
) (
   input  logic [NUM_WORDS-1:0][DATA_W-1:0] q,
   input  logic [IDX_W-1:0]                 idx,
   output logic [DATA_W-1:0]                rdata
);
   if (AND_OR) begin : g_andor
      logic [NUM_WORDS-1:0][DATA_W-1:0] masked;
      for (genvar g = 0; g < NUM_WORDS; g++) begin : g_mask
         assign masked[g] = q[g] & {DATA_W{idx == IDX_W'(g)}};
      end
      always_comb begin
         rdata = '0;
         for (int i = 0; i < NUM_WORDS; i++) rdata = rdata | masked[i];
      end
   end else begin : g_index
      assign rdata = q[idx];
   end
endmodule

// File: rtl/ahb_quad_out.sv
module ahb_quad_out
   import quadout_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          MUX_ANDOR = 1'b1
) (
   input  logic              HCLK,
   input  logic              HRESETn,
   input  logic              HSEL,
   input  logic [ADDR_W-1:0] HADDR,
   input  logic [1:0]        HTRANS,
   input  logic              HWRITE,
   input  logic [2:0]        HSIZE,
   input  logic              HREADY,
   input  logic [DATA_W-1:0] HWDATA,
   output logic [DATA_W-1:0] HRDATA,
   output logic              HREADYOUT,
   output logic              HRESP,
   output logic [DATA_W-1:0] drive_0,
   output logic [DATA_W-1:0] drive_1,
   output logic [DATA_W-1:0] drive_2,
   output logic [DATA_W-1:0] drive_3
);
   logic                             wr_pend;
   logic [IDX_W-1:0]                 idx;
   logic [NUM_WORDS-1:0][DATA_W-1:0] words;

   qo_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk(HCLK), .rst_n(HRESETn), .hsel(HSEL), .haddr(HADDR),
      .htrans(HTRANS), .hwrite(HWRITE), .hsize(HSIZE), .hready(HREADY),
      .wr_pend(wr_pend), .idx(idx)
   );

   qo_reg_bank #(.DATA_W(DATA_W)) u_bank (
      .clk(HCLK), .rst_n(HRESETn), .wr_pend(wr_pend), .hready(HREADY),
      .idx(idx), .wdata(HWDATA), .q(words)
   );

   qo_read_mux #(.DATA_W(DATA_W), .AND_OR(MUX_ANDOR)) u_mux (
      .q(words), .idx(idx), .rdata(HRDATA)
   );

   assign HREADYOUT = 1'b1;
   assign HRESP     = 1'b0;
   assign drive_0   = words[0];
   assign drive_1   = words[1];
   assign drive_2   = words[2];
   assign drive_3   = words[3];
endmodule

// File: tb/tb_ahb_quad_out.sv
`timescale 1ns/1ps
module tb_ahb_quad_out;
   logic        HCLK = 1'b0;
   logic        HRESETn = 1'b0;
   logic        HSEL = 1'b0;
   logic [31:0] HADDR = '0;
   logic [1:0]  HTRANS = 2'b00;
   logic        HWRITE = 1'b0;
   logic [2:0]  HSIZE = 3'b010;
   logic        HREADY = 1'b1;
   logic [31:0] HWDATA = '0;
   logic [31:0] HRDATA, drive_0, drive_1, drive_2, drive_3;
   logic        HREADYOUT, HRESP;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] model [4];

   always #4 HCLK = ~HCLK;

   ahb_quad_out dut (
      .HCLK(HCLK), .HRESETn(HRESETn), .HSEL(HSEL), .HADDR(HADDR),
      .HTRANS(HTRANS), .HWRITE(HWRITE), .HSIZE(HSIZE), .HREADY(HREADY),
      .HWDATA(HWDATA), .HRDATA(HRDATA), .HREADYOUT(HREADYOUT), .HRESP(HRESP),
      .drive_0(drive_0), .drive_1(drive_1), .drive_2(drive_2), .drive_3(drive_3)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_outs(input string req);
      chk({req, " drive_0"}, drive_0, model[0]);
      chk({req, " drive_1"}, drive_1, model[1]);
      chk({req, " drive_2"}, drive_2, model[2]);
      chk({req, " drive_3"}, drive_3, model[3]);
      chk({req, " R2 ready/resp"}, {30'd0, HREADYOUT, HRESP}, 32'd2);
   endtask

   task automatic go_idle();
      HSEL = 1'b0; HTRANS = 2'b00; HWRITE = 1'b0; HSIZE = 3'b010; HREADY = 1'b1;
   endtask

   // address phase on one cycle, data phase on the next; returns at the falling edge after the data phase
   task automatic bus_write(input logic [31:0] a, input logic [31:0] d,
                            input logic [2:0] sz, input logic [1:0] tr, input logic sel,
                            input logic rdy);
      @(negedge HCLK);
      HSEL = sel; HADDR = a; HTRANS = tr; HWRITE = 1'b1; HSIZE = sz; HREADY = rdy;
      @(negedge HCLK);
      go_idle(); HWDATA = d;
      @(negedge HCLK);
   endtask

   task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string req);
      @(negedge HCLK);
      HSEL = 1'b1; HADDR = a; HTRANS = 2'b10; HWRITE = 1'b0; HSIZE = 3'b010;
      @(negedge HCLK);
      go_idle();
      chk(req, HRDATA, exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge HCLK);
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] bases [3];
      bases[0] = 32'h6000_0000; bases[1] = 32'h6ABC_0000; bases[2] = 32'h6FFF_FFF0;
      for (int k = 0; k < 4; k++) model[k] = '0;

      // R1 / R2: reset state
      repeat (3) @(negedge HCLK);
      chk_outs("R1 reset");
      chk("R1 reset HRDATA", HRDATA, 32'd0);
      HRESETn = 1'b1;

      // R3 R5 R9 R4: sweep all words through aliased bases
      for (int b = 0; b < 3; b++) begin
         for (int k = 0; k < 4; k++) begin
            logic [31:0] d;
            d = (32'h1111_1111 * (k + 1)) ^ (32'h0F0F_0000 * (b + 1)) ^ 32'h0000_A5A5;
            bus_write(bases[b] + 32'(4 * k), d, 3'b010, 2'b10, 1'b1, 1'b1);
            model[k] = d;
            chk_outs("R3 R5 R9 write sweep");
         end
         for (int k = 0; k < 4; k++) begin
            bus_read(bases[(b + 1) % 3] + 32'(4 * k) + 32'(b % 4), model[k], "R4 R5 read sweep");
         end
      end

      // SEQ type also accepted (R3)
      bus_write(32'h6000_0008, 32'hCAFE_0002, 3'b010, 2'b11, 1'b1, 1'b1);
      model[2] = 32'hCAFE_0002;
      chk_outs("R3 seq write");

      // R6: IDLE, BUSY, HSEL low, HREADY low
      bus_write(32'h6000_0000, 32'hDEAD_0001, 3'b010, 2'b00, 1'b1, 1'b1);
      chk_outs("R6 idle");
      bus_write(32'h6000_0004, 32'hDEAD_0002, 3'b010, 2'b01, 1'b1, 1'b1);
      chk_outs("R6 busy");
      bus_write(32'h6000_0008, 32'hDEAD_0003, 3'b010, 2'b10, 1'b0, 1'b1);
      chk_outs("R6 hsel low");
      bus_write(32'h6000_000C, 32'hDEAD_0004, 3'b010, 2'b10, 1'b1, 1'b0);
      chk_outs("R6 hready low");

      // R7: non-word sizes
      for (int s = 0; s < 4; s++) begin
         if (s != 2) begin
            bus_write(32'h6000_0004, 32'hBAD0_0000 | 32'(s), 3'(s), 2'b10, 1'b1, 1'b1);
            chk_outs("R7 size");
         end
      end

      // R8: overlapped write then read of the same word
      @(negedge HCLK);
      HSEL = 1'b1; HADDR = 32'h6000_000C; HTRANS = 2'b10; HWRITE = 1'b1; HSIZE = 3'b010;
      @(negedge HCLK);
      HWDATA = 32'h1234_5678; HWRITE = 1'b0; HADDR = 32'h6000_000C;
      @(negedge HCLK);
      go_idle();
      model[3] = 32'h1234_5678;
      chk("R8 overlapped read", HRDATA, 32'h1234_5678);
      chk_outs("R8 outputs");

      // R1: reset during a pending write
      @(negedge HCLK);
      HSEL = 1'b1; HADDR = 32'h6000_0000; HTRANS = 2'b10; HWRITE = 1'b1; HSIZE = 3'b010;
      @(negedge HCLK);
      go_idle(); HWDATA = 32'h7777_7777; HRESETn = 1'b0;
      @(negedge HCLK);
      HRESETn = 1'b1;
      for (int k = 0; k < 4; k++) model[k] = '0;
      @(negedge HCLK);
      chk_outs("R1 reset cancels write");
      bus_read(32'h6000_0000, 32'd0, "R1 R4 read after reset");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule